// File: doc/BRIEF.md
# Hex Value Serial Debug Transmitter

This block lets logic deep inside a design show an internal binary value on a PC terminal. The surrounding logic picks the instant of interest and pulses a one-cycle write strobe. The block takes its own copy of the data word at that moment. It then sends the word as a fixed number of ASCII hexadecimal characters over a single serial line, with the most significant digit first. While a message is on the line, a busy output is high, and the caller must wait for busy to fall before it strobes again.

The clock frequency, the baud rate and the digit count are parameters. The number of clock cycles per bit is computed from the first two. Each character is a standard asynchronous frame: one start bit, eight data bits and one stop bit. Consecutive characters of a message are separated by a single idle clock cycle. The block sends nothing but hex digits, and there is no receive path.

Top module: `hexdbg_tx`

## Requirements
- R1: Out of reset, and whenever busy is low, the serial line is high and busy is low.
- R2: A strobe sampled while busy is low is accepted. Busy is high from the next cycle for exactly DIGITS*(10*DIV+1) cycles.
- R3: Each accepted strobe produces exactly DIGITS characters.
- R4: The first character carries the most significant nibble of the captured word, and each later character carries the next lower nibble.
- R5: Nibble values 0 to 9 are sent as bytes 0x30 to 0x39. Values 10 to 15 are sent as uppercase 0x41 to 0x46.
- R6: Every character is framed as a low start bit, then eight data bits with the least significant bit first, then a high stop bit. The line never goes low while busy is low.
- R7: Every bit lasts DIV clock cycles, where DIV is CLK_HZ/BAUD rounded to the nearest integer. For example, 1 MHz at 95000 baud gives 11, not 10.
- R8: A strobe raised while busy is high is ignored. The message in progress is unchanged, and no further message follows it.
- R9: The word is latched on the accepted strobe. Changes on wr_data during the message do not alter the characters sent.
- R10: A synchronous active-high reset forces the line high and busy low on the next cycle. Any partly sent message is dropped and does not resume.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | One-cycle request to capture and send wr_data |
| wr_data | input | 4*DIGITS | Binary value to show |
| txd | output | 1 | Serial output, idles high |
| busy | output | 1 | High while a message is being sent |

## Verification
Any fault in the digit counter or the word shift shows up when the message ends: the busy window has the wrong length, or the wrong number of characters arrives. Either is visible within one message time. A wrong bit counter or divider makes start, data or stop samples land on the wrong bits, which corrupts the first character decoded. An error in the capture or busy guard only shows up when the data input changes or a second strobe arrives during a message. For that reason, both are driven mid-message and the received characters are compared with the latched word.

// File: rtl/hexdbg_pkg.sv
`timescale 1ns/1ps
package hexdbg_pkg;

    localparam int FRAME_BITS = 10;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOAD = 2'd1,
        SEQ_SEND = 2'd2
    } seq_state_e;

    function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
        if (n < 4'd10) return 8'h30 + {4'h0, n};
        else           return 8'h37 + {4'h0, n};
    endfunction

endpackage

// File: rtl/hexdbg_nib_enc.sv
`timescale 1ns/1ps
module hexdbg_nib_enc
    import hexdbg_pkg::*;
(
    input  logic [3:0] nib_i,
    output logic [7:0] char_o
);
    always_comb begin
        char_o = nib_to_ascii(nib_i);
    end
endmodule

// File: rtl/hexdbg_bitclk.sv
`timescale 1ns/1ps
module hexdbg_bitclk #(
    parameter int DIV = 434
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == CW'(DIV - 1));
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/hexdbg_ser.sv
`timescale 1ns/1ps
module hexdbg_ser
    import hexdbg_pkg::*;
#(
    parameter int DIV = 434
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] byte_i,
    output logic       txd,
    output logic       fin
);
    typedef struct packed {
        logic                  act;
        logic [3:0]            bitn;
        logic [FRAME_BITS-1:0] frame;
    } ser_t;

    localparam ser_t SER_RST = '{act: 1'b0, bitn: 4'd0, frame: '1};

    ser_t r_d, r_q;
    logic tick;

    hexdbg_bitclk #(.DIV(DIV)) u_bitclk (
        .clk  (clk),
        .rst  (rst),
        .run  (r_q.act),
        .tick (tick)
    );

    always_comb begin
        r_d = r_q;
        fin = r_q.act && tick && (r_q.bitn == 4'(FRAME_BITS - 1));
        if (!r_q.act) begin
            if (load) begin
                r_d.act   = 1'b1;
                r_d.bitn  = 4'd0;
                r_d.frame = {1'b1, byte_i, 1'b0};
            end
        end else if (tick) begin
            r_d.frame = {1'b1, r_q.frame[FRAME_BITS-1:1]};
            if (fin) r_d.act  = 1'b0;
            else     r_d.bitn = r_q.bitn + 4'd1;
        end
        txd = r_q.act ? r_q.frame[0] : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= SER_RST;
        else     r_q <= r_d;
    end
endmodule

// File: rtl/hexdbg_tx.sv
`timescale 1ns/1ps
module hexdbg_tx
    import hexdbg_pkg::*;
#(
    parameter  int CLK_HZ = 50_000_000,
    parameter  int BAUD   = 115_200,
    parameter  int DIGITS = 8,
    localparam int WORD_W = 4 * DIGITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [WORD_W-1:0] wr_data,
    output logic              txd,
    output logic              busy
);
    localparam int DIV   = (CLK_HZ + BAUD / 2) / BAUD;
    localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;

    typedef struct packed {
        seq_state_e        st;
        logic [WORD_W-1:0] word;
        logic [IDX_W-1:0]  idx;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: SEQ_IDLE, word: '0, idx: '0};

    seq_t       s_d, s_q;
    logic       load;
    logic       fin;
    logic [7:0] char_w;

    hexdbg_nib_enc u_enc (
        .nib_i  (s_q.word[WORD_W-1 -: 4]),
        .char_o (char_w)
    );

    hexdbg_ser #(.DIV(DIV)) u_ser (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .byte_i (char_w),
        .txd    (txd),
        .fin    (fin)
    );

    always_comb begin
        s_d  = s_q;
        load = 1'b0;
        case (s_q.st)
            SEQ_IDLE: begin
                if (wr_stb) begin
                    s_d.st   = SEQ_LOAD;
                    s_d.word = wr_data;
                    s_d.idx  = '0;
                end
            end
            SEQ_LOAD: begin
                load   = 1'b1;
                s_d.st = SEQ_SEND;
            end
            SEQ_SEND: begin
                if (fin) begin
                    if (s_q.idx == IDX_W'(DIGITS - 1)) begin
                        s_d.st = SEQ_IDLE;
                    end else begin
                        s_d.st   = SEQ_LOAD;
                        s_d.idx  = s_q.idx + IDX_W'(1);
                        s_d.word = s_q.word << 4;
                    end
                end
            end
            default: s_d.st = SEQ_IDLE;
        endcase
        busy = (s_q.st != SEQ_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= SEQ_RST;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/hexdbg_tx_chk.sv
`timescale 1ns/1ps
module hexdbg_tx_chk #(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 115_200
) (
    input logic clk,
    input logic rst,
    input logic wr_stb,
    input logic txd,
    input logic busy
);
    localparam int DIV = (CLK_HZ + BAUD / 2) / BAUD;

    logic     prev_q;
    int       run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            run_q  <= 0;
        end else begin
            prev_q <= txd;
            if (txd != prev_q) run_q <= 1;
            else               run_q <= run_q + 1;
        end
    end

    a_r1_line_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    a_r2_accept: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_stb) |=> busy);

    a_r2_rise_from_stb: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wr_stb));

    a_r6_start_in_msg: assert property (@(posedge clk) disable iff (rst)
        $fell(txd) |-> busy);

    a_r7_low_run: assert property (@(posedge clk) disable iff (rst)
        (!prev_q && txd) |-> ((run_q > 0) && (run_q % DIV == 0)));

    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (!busy && txd));

endmodule

bind hexdbg_tx hexdbg_tx_chk #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_stb (wr_stb),
    .txd    (txd),
    .busy   (busy)
);

// File: tb/tb_hexdbg_tx.sv
`timescale 1ns/1ps
module tb_hexdbg_tx;
    localparam int CLK_HZ  = 1_000_000;
    localparam int BAUD    = 95_000;
    localparam int DIGITS  = 5;
    localparam int WW      = 4 * DIGITS;
    localparam int BIT_CYC = (CLK_HZ + BAUD / 2) / BAUD;
    localparam int MSG_CYC = DIGITS * (10 * BIT_CYC + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_stb = 1'b0;
    logic [WW-1:0] wr_data = '0;
    logic          txd;
    logic          busy;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    logic [8:0] rxq[$];

    always #2.5 clk = ~clk;

    hexdbg_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DIGITS(DIGITS)) dut (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .txd     (txd),
        .busy    (busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_char(input logic [3:0] n);
        if (n <= 4'd9) return 8'h30 + {4'h0, n};
        return 8'h41 + {4'h0, n} - 8'd10;
    endfunction

    // Line monitor: decodes frames by mid-bit sampling, records framing status.
    initial begin
        logic       prev;
        logic [7:0] b;
        bit         ok;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (rst) begin
                prev = 1'b1;
            end else if (prev && !txd) begin
                ok = 1'b1;
                repeat (BIT_CYC / 2) @(negedge clk);
                if (txd) ok = 1'b0;
                for (int i = 0; i < 8; i++) begin
                    repeat (BIT_CYC) @(negedge clk);
                    b[i] = txd;
                end
                repeat (BIT_CYC) @(negedge clk);
                if (!txd) ok = 1'b0;
                rxq.push_back({ok, b});
                prev = 1'b1;
            end else begin
                prev = txd;
            end
        end
    end

    task automatic send_msg(input logic [WW-1:0] w, input bit meddle);
        int cnt;
        logic [7:0] e;
        rxq.delete();
        @(negedge clk);
        wr_data = w;
        wr_stb  = 1'b1;
        @(negedge clk);
        wr_stb  = 1'b0;
        chk(busy == 1'b1, "R2 busy after strobe", int'(busy), 1);
        cnt = 0;
        while (busy && cnt < MSG_CYC + 50) begin
            cnt++;
            if (meddle) begin
                if (cnt == 30) wr_data = ~w;
                if (cnt == 60) wr_stb = 1'b1;
                if (cnt == 61) wr_stb = 1'b0;
                if (cnt == 10 * BIT_CYC + 1) wr_stb = 1'b1;
                if (cnt == 10 * BIT_CYC + 2) wr_stb = 1'b0;
            end
            @(negedge clk);
        end
        chk(cnt == MSG_CYC, "R2,R7 busy duration", cnt, MSG_CYC);
        repeat (3) @(negedge clk);
        chk(rxq.size() == DIGITS, "R3 character count", rxq.size(), DIGITS);
        for (int i = 0; i < DIGITS && i < rxq.size(); i++) begin
            e = exp_char(w[WW-1-4*i -: 4]);
            chk(rxq[i][7:0] == e, meddle ? "R9 latched character" : "R4,R5 character value",
                int'(rxq[i][7:0]), int'(e));
            chk(rxq[i][8] == 1'b1, "R6 start/stop framing", int'(rxq[i][8]), 1);
        end
        if (meddle) begin
            repeat (20) @(negedge clk);
            chk(!busy && rxq.size() == DIGITS, "R8 strobe during busy ignored",
                rxq.size() + (busy ? 100 : 0), DIGITS);
        end
    endtask

    initial begin
        logic [WW-1:0] w;
        int lows;
        int busy_seen;
        repeat (3) @(negedge clk);
        chk(txd == 1'b1, "R1 line high in reset", int'(txd), 1);
        chk(busy == 1'b0, "R1 busy low in reset", int'(busy), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk(txd == 1'b1 && busy == 1'b0, "R1 idle after reset", int'({busy, txd}), 1);

        send_msg(20'h00000, 1'b0);
        send_msg(20'hFFFFF, 1'b0);
        send_msg(20'h12345, 1'b0);
        send_msg(20'hABCDE, 1'b1);
        send_msg(20'h9A0F5, 1'b1);

        void'($urandom(32'h5EED));
        for (int k = 0; k < 20; k++) begin
            w = WW'($urandom);
            send_msg(w, (k % 3) == 0);
        end

        // R10: reset in the middle of a message
        @(negedge clk);
        wr_data = 20'h7C3B1;
        wr_stb  = 1'b1;
        @(negedge clk);
        wr_stb  = 1'b0;
        repeat (150) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R10 busy cleared by reset", int'(busy), 0);
        chk(txd == 1'b1, "R10 line high after reset", int'(txd), 1);
        rst = 1'b0;
        repeat (200) @(negedge clk);
        rxq.delete();
        lows = 0;
        busy_seen = 0;
        for (int c = 0; c < 1500; c++) begin
            @(negedge clk);
            if (!txd) lows++;
            if (busy) busy_seen++;
        end
        chk(lows == 0 && busy_seen == 0, "R10 message dropped", lows + busy_seen, 0);
        chk(rxq.size() == 0, "R10 no characters after reset", rxq.size(), 0);
        send_msg(20'h0F1E2, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule